// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Timing Tracker

This block sits beside the command scheduler of a DDR SDRAM controller and follows every bank through the automatic precharge that a READ or WRITE can request. The scheduler presents each row activate and each READ/WRITE to the tracker as it is issued. The tracker answers, for every bank, whether a command may be issued to it now and whether its internal precharge is currently running.

A READ or WRITE asks for auto precharge through a per-command flag, the column-command address bit 10. The flag applies to that command only. The precharge of that bank does not simply start when the burst ends. It starts at the later of two cycles: the burst finishing, or the earliest cycle at which an explicit precharge would meet the minimum activate-to-precharge time. After that the bank stays locked for the row precharge time. Each bank keeps its own age counter, which restarts on an activate, so the activate-to-precharge limit is judged separately for every bank. Other banks keep working while one bank waits or precharges.

The minimum activate-to-precharge time, the precharge time and the burst duration are configuration inputs, given in clock cycles. They must be held stable while any bank is locked.

Top module: `ap_bank_tracker`

## Requirements
- R1: After reset every bank reports ready=1 and busy=0, and its age counter is saturated, so that a row counts as open long enough.
- R2: A READ/WRITE with the auto-precharge flag at 0 leaves that bank's ready at 1 and its busy at 0.
- R3: A READ/WRITE with auto precharge registered at edge E, on a bank whose activate lies at least `cfg_tras` edges before E+`cfg_bl`, starts the precharge at edge E+`cfg_bl`. Busy is 1 from that edge on.
- R4: If the bank's activate was registered at edge A and A+`cfg_tras` is later than E+`cfg_bl`, the precharge starts at edge A+`cfg_tras`.
- R5: Busy stays at 1 for exactly `cfg_trp` cycles after the precharge start edge.
- R6: Ready is 0 from the auto-precharge command edge until the precharge start edge plus `cfg_trp`, and is 1 again at that edge.
- R7: An activate or READ/WRITE aimed at a bank whose ready is 0 is dropped. The bank's precharge start and end edges do not change.
- R8: Banks are independent. Commands to other banks, including an activate and a READ/WRITE in the same cycle, are accepted while one bank is pending or precharging, and they do not shift that bank's timing.
- R9: The auto-precharge selection does not persist. After a bank finishes an auto precharge and is activated again, a READ/WRITE without the flag leaves it ready.
- R10: A bank's age counter saturates and does not wrap. For a row held open longer than the counter range, the precharge starts at E+`cfg_bl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_vld | input | 1 | Row activate issued this cycle |
| act_bank | input | BW | Bank of the activate |
| rw_vld | input | 1 | READ or WRITE issued this cycle |
| rw_bank | input | BW | Bank of the READ/WRITE |
| rw_ap | input | 1 | Auto-precharge flag (address bit 10) of the READ/WRITE |
| cfg_tras | input | TW | Minimum activate-to-precharge time, cycles |
| cfg_trp | input | TW | Precharge time, cycles (at least 1) |
| cfg_bl | input | TW | Burst duration, cycles (at least 1) |
| bank_busy | output | NBANK | Internal precharge running, per bank |
| bank_ready | output | NBANK | Bank accepts a command, per bank |

## Verification
A wrong age counter or a wrong burst countdown appears as a busy edge that is early or late, and it shows within one cycle of the correct precharge start. A wrong precharge count appears as ready returning at the wrong edge. A dropped-command fault or a crossed bank index moves a lock window or creates a false one on a neighbouring bank. The bench therefore models each bank's expected window and compares ready and busy for every bank on every cycle, so any such fault shows up in the first cycle where the two disagree.

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker #(
  parameter int NBANK = 4,
  parameter int TW    = 6,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_vld,
  input  logic [BW-1:0]    act_bank,
  input  logic             rw_vld,
  input  logic [BW-1:0]    rw_bank,
  input  logic             rw_ap,
  input  logic [TW-1:0]    cfg_tras,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_bl,
  output logic [NBANK-1:0] bank_busy,
  output logic [NBANK-1:0] bank_ready
);

  typedef enum logic [1:0] {S_RDY, S_PEND, S_PRE} st_t;

  localparam logic [TW-1:0] ONE = TW'(1);

  st_t           st  [NBANK];
  logic [TW-1:0] age [NBANK];
  logic [TW-1:0] cnt [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          act_hit, rw_hit, start;
    logic [TW:0]   age_nx;

    assign act_hit = act_vld && (act_bank == BW'(b)) && (st[b] == S_RDY);
    assign rw_hit  = rw_vld  && (rw_bank  == BW'(b)) && (st[b] == S_RDY);
    assign age_nx  = {1'b0, age[b]} + 1'b1;
    assign start   = (st[b] == S_PEND) && (cnt[b] <= ONE) && (age_nx >= {1'b0, cfg_tras});

    always_ff @(posedge clk) begin
      if (!rst_n)              age[b] <= '1;
      else if (act_hit)        age[b] <= '0;
      else if (age[b] != '1)   age[b] <= age[b] + ONE;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[b]  <= S_RDY;
        cnt[b] <= '0;
      end else begin
        case (st[b])
          S_RDY: if (rw_hit && rw_ap) begin
            st[b]  <= S_PEND;
            cnt[b] <= cfg_bl;
          end
          S_PEND: begin
            if (start) begin
              st[b]  <= S_PRE;
              cnt[b] <= cfg_trp;
            end else if (cnt[b] > ONE) begin
              cnt[b] <= cnt[b] - ONE;
            end
          end
          S_PRE: begin
            if (cnt[b] <= ONE) st[b] <= S_RDY;
            else               cnt[b] <= cnt[b] - ONE;
          end
          default: st[b] <= S_RDY;
        endcase
      end
    end

    assign bank_ready[b] = (st[b] == S_RDY);
    assign bank_busy[b]  = (st[b] == S_PRE);

    a_r4_tras_met: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_busy[b]) |-> (age[b] >= cfg_tras));
    a_r5_ready_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_busy[b]) |-> bank_ready[b]);
    a_r6_ap_locks: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_vld && rw_ap && rw_bank == BW'(b) && bank_ready[b]) |=> !bank_ready[b]);
    a_r2_plain_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
      (rw_vld && !rw_ap && rw_bank == BW'(b) && bank_ready[b]) |=> bank_ready[b]);
    a_r7_act_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && act_bank == BW'(b) && !bank_ready[b]) |=> (age[b] != '0));
  end

endmodule

// File: tb/tb_ap_bank_tracker.sv
module tb_ap_bank_tracker;
  localparam int NB = 4;
  localparam int TW = 6;
  localparam int BW = 2;

  logic clk = 0, rst_n = 0;
  logic act_vld = 0, rw_vld = 0, rw_ap = 0;
  logic [BW-1:0] act_bank = '0, rw_bank = '0;
  logic [TW-1:0] cfg_tras = 6'd10, cfg_trp = 6'd3, cfg_bl = 6'd4;
  logic [NB-1:0] bank_busy, bank_ready;

  int ecnt = 0;
  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  int ea [NB];
  int er [NB];
  int xs [NB];

  ap_bank_tracker #(.NBANK(NB), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_bank(act_bank),
    .rw_vld(rw_vld), .rw_bank(rw_bank), .rw_ap(rw_ap),
    .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_bl(cfg_bl),
    .bank_busy(bank_busy), .bank_ready(bank_ready));

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic bit exp_ready(int b, int n);
    return !(n >= er[b] && n < xs[b] + int'(cfg_trp));
  endfunction

  function automatic bit exp_busy(int b, int n);
    return (n >= xs[b] && n < xs[b] + int'(cfg_trp));
  endfunction

  task automatic check_all();
    for (int b = 0; b < NB; b++) begin
      n_chk++;
      if (bank_ready[b] !== exp_ready(b, ecnt)) begin
        n_bad++;
        $display("FAIL %s (R6 ready) bank %0d edge %0d: got %b exp %b",
                 cur_req, b, ecnt, bank_ready[b], exp_ready(b, ecnt));
      end
      n_chk++;
      if (bank_busy[b] !== exp_busy(b, ecnt)) begin
        n_bad++;
        $display("FAIL %s (R5 busy) bank %0d edge %0d: got %b exp %b",
                 cur_req, b, ecnt, bank_busy[b], exp_busy(b, ecnt));
      end
    end
  endtask

  task automatic tick();
    check_all();
    @(negedge clk);
    act_vld = 0;
    rw_vld  = 0;
    rw_ap   = 0;
  endtask

  task automatic idle(int k);
    repeat (k) tick();
  endtask

  task automatic drv_act(int b);
    act_vld  = 1;
    act_bank = BW'(b);
    if (exp_ready(b, ecnt)) ea[b] = ecnt + 1;
  endtask

  task automatic drv_rw(int b, bit ap);
    int e, xa;
    rw_vld  = 1;
    rw_bank = BW'(b);
    rw_ap   = ap;
    e = ecnt + 1;
    if (ap && exp_ready(b, ecnt)) begin
      xa = ea[b] + int'(cfg_tras);
      er[b] = e;
      xs[b] = (e + int'(cfg_bl) > xa) ? e + int'(cfg_bl) : xa;
    end
  endtask

  task automatic t_reset();
    cur_req = "R1";
    for (int b = 0; b < NB; b++) begin
      n_chk++;
      if (bank_ready[b] !== 1'b1 || bank_busy[b] !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 bank %0d: ready/busy got %b%b exp 10", b, bank_ready[b], bank_busy[b]);
      end
    end
    idle(2);
  endtask

  task automatic t_no_ap();
    cur_req = "R2";
    drv_act(0); tick(); idle(2);
    drv_rw(0, 0); tick(); idle(12);
  endtask

  task automatic t_burst_bound();
    cur_req = "R3";
    drv_act(0); tick(); idle(12);
    drv_rw(0, 1); tick(); idle(12);
  endtask

  task automatic t_tras_bound();
    cur_req = "R4";
    drv_act(1); tick(); idle(1);
    drv_rw(1, 1); tick(); idle(16);
  endtask

  task automatic t_drop();
    cur_req = "R7";
    drv_act(2); tick();
    drv_rw(2, 1); tick(); idle(2);
    drv_act(2); tick();
    drv_rw(2, 1); tick(); idle(16);
  endtask

  task automatic t_multi();
    cur_req = "R8";
    drv_act(0); tick(); idle(11);
    drv_act(3); drv_rw(0, 1); tick();
    drv_rw(3, 1); tick(); idle(2);
    drv_act(1); tick();
    drv_rw(1, 0); tick(); idle(20);
  endtask

  task automatic t_repeat();
    cur_req = "R9";
    drv_act(1); tick(); idle(12);
    drv_rw(1, 1); tick(); idle(20);
    drv_act(1); tick(); idle(12);
    drv_rw(1, 0); tick(); idle(8);
  endtask

  task automatic t_saturate();
    cur_req = "R10";
    cfg_tras = 6'd60; cfg_trp = 6'd1; cfg_bl = 6'd1;
    drv_act(2); tick(); idle(100);
    drv_rw(2, 1); tick(); idle(6);
    drv_act(3); tick(); idle(3);
    drv_rw(3, 1); tick(); idle(64);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      ea[b] = -1000; er[b] = -1000; xs[b] = -1000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_ap();
    t_burst_bound();
    t_tras_bound();
    t_drop();
    t_multi();
    t_repeat();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired at edge %0d (%s)", ecnt, cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule